// File: doc/BRIEF.md
# Hashed Page Table Group Searcher

This block walks one group of eight translation entries in a 32-bit hashed page table and decides the outcome of a lookup. A lookup is launched with a table base address, a group offset, the hash selector (primary or secondary), the access kind (load or store), the protection key, and the virtual segment tag and page index to match. The block fetches entry words one at a time through a valid/ready read port. For each slot it reads the first word, and it reads the second word only when the first word matches. It then classifies the entry and reports one of four outcomes: hit, protection violation, miss or inconsistency.

When a slot is chosen, the block merges the referenced and changed flags into that entry's second word. A slot is chosen by a hit, or by a violation that no later slot overrides. The merged word is written back through a valid/ready write port only when a flag bit actually changes. The outcome, the chosen slot and its real page number are reported with a one-cycle done pulse.

Back-pressure rules: a read or write request is held with a stable address and data until the memory accepts it. At most one read is outstanding. The read response is accepted only while the block is waiting for it, and it never waits on the block for more than a cycle. Control pins (start, busy, done and the result fields) are plain levels and pulses.

Top module: `hpt_group_search`

## Requirements
- R1: Slots are visited in ascending order from 0 to 7. The first word of slot s is read from address tbl_base + grp_off + 8*s, and the second word is read from that address plus 4.
- R2: An entry matches only if all of these hold: first-word bit 31 (valid) is 1, bit 6 (hash flag) equals hsel, bits 30:7 equal vsid, and bits 5:0 equal api. For a slot that does not match, no second-word read is issued.
- R3: Protection uses pp = second-word bits 1:0. With key 0, pp 11 is read-only and every other value is read/write. With key 1, pp 00 gives no access, pp 01 and 11 are read-only, and pp 10 is read/write. A load needs read access and a store needs write access.
- R4: The first matching slot that grants access ends the search at once with result 00 (hit). The block reports that slot and the page number from second-word bits 31:12, and issues no further reads.
- R5: A matching slot that denies access is recorded, and the scan continues. If the scan then ends without a hit or inconsistency, the result is 01 (violation), reported with the last violating slot and its page number.
- R6: A matching slot whose page number differs from that of a recorded violation ends the search at once with result 11 (inconsistent), slot 0 and page 0. There is no write-back and no further reads.
- R7: If no slot matches, the result is 10 (miss) with slot 0 and page 0, and there is no write-back.
- R8: On a hit or a violation, the chosen second word gets bit 8 (referenced) set, and bit 7 (changed) is set only on a hit by a store. The merged word is written to that slot's second-word address only if it differs from the word that was read.
- R9: rd_req_valid and rd_addr hold until rd_req_ready. wr_valid, wr_addr and wr_data hold until wr_ready. One read at most is outstanding, and rd_rsp_ready is high only while a response is awaited.
- R10: start is taken only while busy is 0, and the request inputs are captured at that cycle. busy stays 1 until done, which is a single-cycle pulse. A start raised while busy has no effect.
- R11: After reset the block is idle: busy, done, rd_req_valid and wr_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch a search (taken when idle) |
| tbl_base | input | AW | Table base address |
| grp_off | input | AW | Byte offset of the group in the table |
| hsel | input | 1 | Hash selector: 0 primary, 1 secondary |
| store | input | 1 | Access kind: 1 store, 0 load |
| key | input | 1 | Protection key |
| vsid | input | 24 | Segment tag to match |
| api | input | 6 | Page index to match |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 00 hit, 01 violation, 10 miss, 11 inconsistent |
| slot | output | log2(NSLOT) | Chosen slot |
| rpn | output | 20 | Real page number of chosen slot |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_addr | output | AW | Read byte address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_ready | output | 1 | Block can take read data |
| rd_rsp_data | input | 32 | Read data |
| wr_valid | output | 1 | Write-back request valid |
| wr_ready | input | 1 | Write-back accepted |
| wr_addr | output | AW | Write-back byte address |
| wr_data | output | 32 | Write-back data |

## Verification
The bench checks these corner cases:
- A violation followed by a later grant. A design that stopped on the first violation would report 01 at the wrong slot.
- A violation followed by a clashing page number. A design that kept scanning, or that still wrote back, would report a hit or miss and issue an extra write.
- Violations in two slots. Reporting the first violating slot instead of the last would be caught.
- Entries whose flags are already set. A design that always writes back is exposed here.
- A store hit against a store violation. This separates setting the changed bit from setting only the referenced bit.
- Tag and hash-flag mismatches, counted by exact read totals. A design that fetches the second word of every slot fails here.
- A start pulse in mid-search. A design that re-captures inputs would read outside the first group.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

  localparam int WORD_W  = 32;
  localparam int VSID_W  = 24;
  localparam int API_W   = 6;
  localparam int RPN_W   = 20;
  localparam int V_BIT   = 31;
  localparam int H_BIT   = 6;
  localparam int REF_BIT = 8;
  localparam int CHG_BIT = 7;
  localparam int ENTRY_SHIFT = 3;   // 8 bytes per entry
  localparam int HI_WORD_OFS = 4;   // second word follows first

  typedef enum logic [1:0] {
    RES_HIT   = 2'b00,
    RES_VIOL  = 2'b01,
    RES_MISS  = 2'b10,
    RES_INCON = 2'b11
  } res_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ0,
    ST_WAIT0,
    ST_REQ1,
    ST_WAIT1,
    ST_WB,
    ST_DONE
  } st_e;

  // read/write rights for a protection code under a key
  function automatic logic pp_allows(input logic [1:0] pp, input logic key,
                                     input logic is_store);
    logic rd_ok;
    logic wr_ok;
    rd_ok = !(key && (pp == 2'b00));
    wr_ok = key ? (pp == 2'b10) : (pp != 2'b11);
    return is_store ? wr_ok : rd_ok;
  endfunction

endpackage

// File: rtl/hpt_slot_addr.sv
module hpt_slot_addr
  import hpt_pkg::*;
#(
  parameter int AW = 32,
  parameter int SW = 3
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] off,
  input  logic [SW-1:0] slot,
  input  logic          hi,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] slot_ofs;
  logic [AW-1:0] word_ofs;

  always_comb begin
    slot_ofs = AW'(slot) << ENTRY_SHIFT;
    word_ofs = hi ? AW'(HI_WORD_OFS) : '0;
    addr     = base + off + slot_ofs + word_ofs;
  end
endmodule

// File: rtl/hpt_entry_classify.sv
module hpt_entry_classify
  import hpt_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic              hsel,
  input  logic              key,
  input  logic              store,
  input  logic [VSID_W-1:0] vsid,
  input  logic [API_W-1:0]  api,
  input  logic              rec_valid,
  input  logic [RPN_W-1:0]  rec_rpn,
  output logic              tag_hit,    // meaningful for a first word
  output logic              grant,      // meaningful for a second word
  output logic              rpn_clash,  // meaningful for a second word
  output logic [RPN_W-1:0]  rpn
);
  always_comb begin
    tag_hit = word[V_BIT]
           && (word[H_BIT] == hsel)
           && (word[V_BIT-1 -: VSID_W] == vsid)
           && (word[API_W-1:0] == api);
    rpn       = word[WORD_W-1 -: RPN_W];
    grant     = pp_allows(word[1:0], key, store);
    rpn_clash = rec_valid && (rpn != rec_rpn);
  end
endmodule

// File: rtl/hpt_flag_merge.sv
module hpt_flag_merge
  import hpt_pkg::*;
(
  input  logic [WORD_W-1:0] w_old,
  input  logic              set_chg,
  output logic [WORD_W-1:0] w_new,
  output logic              changed
);
  always_comb begin
    w_new          = w_old;
    w_new[REF_BIT] = 1'b1;
    if (set_chg) w_new[CHG_BIT] = 1'b1;
    changed = (w_new[REF_BIT] != w_old[REF_BIT])
           || (w_new[CHG_BIT] != w_old[CHG_BIT]);
  end
endmodule

// File: rtl/hpt_group_search.sv
module hpt_group_search
  import hpt_pkg::*;
#(
  parameter int AW    = 32,
  parameter int NSLOT = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [AW-1:0]            tbl_base,
  input  logic [AW-1:0]            grp_off,
  input  logic                     hsel,
  input  logic                     store,
  input  logic                     key,
  input  logic [VSID_W-1:0]        vsid,
  input  logic [API_W-1:0]         api,
  output logic                     busy,
  output logic                     done,
  output logic [1:0]               result,
  output logic [$clog2(NSLOT)-1:0] slot,
  output logic [RPN_W-1:0]         rpn,
  output logic                     rd_req_valid,
  input  logic                     rd_req_ready,
  output logic [AW-1:0]            rd_addr,
  input  logic                     rd_rsp_valid,
  output logic                     rd_rsp_ready,
  input  logic [WORD_W-1:0]        rd_rsp_data,
  output logic                     wr_valid,
  input  logic                     wr_ready,
  output logic [AW-1:0]            wr_addr,
  output logic [WORD_W-1:0]        wr_data
);
  localparam int SW = $clog2(NSLOT);
  localparam logic [SW-1:0] LAST = SW'(NSLOT - 1);

  st_e               st;
  logic [SW-1:0]     slot_q;
  logic [AW-1:0]     base_q, off_q;
  logic              hsel_q, store_q, key_q;
  logic [VSID_W-1:0] vsid_q;
  logic [API_W-1:0]  api_q;
  logic              viol_seen;
  logic [SW-1:0]     viol_slot;
  logic [WORD_W-1:0] viol_w1;
  logic [SW-1:0]     ch_slot;
  logic [WORD_W-1:0] ch_w1;
  logic              ch_setc;
  res_e              res_q;
  logic [SW-1:0]     slot_out;
  logic [RPN_W-1:0]  rpn_out;

  logic              tag_hit, grant, rpn_clash;
  logic [RPN_W-1:0]  rpn_w;
  logic [WORD_W-1:0] w1_new;
  logic              w1_chg;

  hpt_slot_addr #(.AW(AW), .SW(SW)) u_rd_addr (
    .base (base_q),
    .off  (off_q),
    .slot (slot_q),
    .hi   (st == ST_REQ1),
    .addr (rd_addr)
  );

  hpt_slot_addr #(.AW(AW), .SW(SW)) u_wr_addr (
    .base (base_q),
    .off  (off_q),
    .slot (ch_slot),
    .hi   (1'b1),
    .addr (wr_addr)
  );

  hpt_entry_classify u_cls (
    .word      (rd_rsp_data),
    .hsel      (hsel_q),
    .key       (key_q),
    .store     (store_q),
    .vsid      (vsid_q),
    .api       (api_q),
    .rec_valid (viol_seen),
    .rec_rpn   (viol_w1[WORD_W-1 -: RPN_W]),
    .tag_hit   (tag_hit),
    .grant     (grant),
    .rpn_clash (rpn_clash),
    .rpn       (rpn_w)
  );

  hpt_flag_merge u_flags (
    .w_old   (ch_w1),
    .set_chg (ch_setc),
    .w_new   (w1_new),
    .changed (w1_chg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      slot_q    <= '0;
      base_q    <= '0;
      off_q     <= '0;
      hsel_q    <= 1'b0;
      store_q   <= 1'b0;
      key_q     <= 1'b0;
      vsid_q    <= '0;
      api_q     <= '0;
      viol_seen <= 1'b0;
      viol_slot <= '0;
      viol_w1   <= '0;
      ch_slot   <= '0;
      ch_w1     <= '0;
      ch_setc   <= 1'b0;
      res_q     <= RES_MISS;
      slot_out  <= '0;
      rpn_out   <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (start) begin
            base_q    <= tbl_base;
            off_q     <= grp_off;
            hsel_q    <= hsel;
            store_q   <= store;
            key_q     <= key;
            vsid_q    <= vsid;
            api_q     <= api;
            slot_q    <= '0;
            viol_seen <= 1'b0;
            st        <= ST_REQ0;
          end
        end
        ST_REQ0: if (rd_req_ready) st <= ST_WAIT0;
        ST_WAIT0: begin
          if (rd_rsp_valid) begin
            if (tag_hit) begin
              st <= ST_REQ1;
            end else if (slot_q != LAST) begin
              slot_q <= slot_q + 1'b1;
              st     <= ST_REQ0;
            end else if (viol_seen) begin
              res_q    <= RES_VIOL;
              slot_out <= viol_slot;
              rpn_out  <= viol_w1[WORD_W-1 -: RPN_W];
              ch_slot  <= viol_slot;
              ch_w1    <= viol_w1;
              ch_setc  <= 1'b0;
              st       <= ST_WB;
            end else begin
              res_q    <= RES_MISS;
              slot_out <= '0;
              rpn_out  <= '0;
              st       <= ST_DONE;
            end
          end
        end
        ST_REQ1: if (rd_req_ready) st <= ST_WAIT1;
        ST_WAIT1: begin
          if (rd_rsp_valid) begin
            if (rpn_clash) begin
              res_q    <= RES_INCON;
              slot_out <= '0;
              rpn_out  <= '0;
              st       <= ST_DONE;
            end else if (grant) begin
              res_q    <= RES_HIT;
              slot_out <= slot_q;
              rpn_out  <= rpn_w;
              ch_slot  <= slot_q;
              ch_w1    <= rd_rsp_data;
              ch_setc  <= store_q;
              st       <= ST_WB;
            end else begin
              viol_seen <= 1'b1;
              viol_slot <= slot_q;
              viol_w1   <= rd_rsp_data;
              if (slot_q == LAST) begin
                res_q    <= RES_VIOL;
                slot_out <= slot_q;
                rpn_out  <= rpn_w;
                ch_slot  <= slot_q;
                ch_w1    <= rd_rsp_data;
                ch_setc  <= 1'b0;
                st       <= ST_WB;
              end else begin
                slot_q <= slot_q + 1'b1;
                st     <= ST_REQ0;
              end
            end
          end
        end
        ST_WB:   if (!w1_chg || wr_ready) st <= ST_DONE;
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy         = (st != ST_IDLE);
    done         = (st == ST_DONE);
    result       = res_q;
    slot         = slot_out;
    rpn          = rpn_out;
    rd_req_valid = (st == ST_REQ0) || (st == ST_REQ1);
    rd_rsp_ready = (st == ST_WAIT0) || (st == ST_WAIT1);
    wr_valid     = (st == ST_WB) && w1_chg;
    wr_data      = w1_new;
  end

endmodule

// File: rtl/hpt_group_search_chk.sv
module hpt_group_search_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic [1:0]    result,
  input logic          rd_req_valid,
  input logic          rd_req_ready,
  input logic [AW-1:0] rd_addr,
  input logic          rd_rsp_ready,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic [31:0]   wr_data
);
  a_r9_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_addr));

  a_r9_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  a_r9_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_valid && rd_rsp_ready));

  a_r9_no_mixed_traffic: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_valid && wr_valid));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req_valid && !wr_valid && !done);

  a_r8_ref_set: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_data[8]);

  a_r6_incon_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    done && (result == 2'b11) |-> !$past(wr_valid));
endmodule

bind hpt_group_search hpt_group_search_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .done         (done),
  .result       (result),
  .rd_req_valid (rd_req_valid),
  .rd_req_ready (rd_req_ready),
  .rd_addr      (rd_addr),
  .rd_rsp_ready (rd_rsp_ready),
  .wr_valid     (wr_valid),
  .wr_ready     (wr_ready),
  .wr_addr      (wr_addr),
  .wr_data      (wr_data)
);

// File: tb/hpt_group_search_tb.sv
`timescale 1ns/1ps
module hpt_group_search_tb;
  localparam logic [31:0] TBASE = 32'h0001_0000;
  localparam logic [23:0] VS    = 24'h5A5A5A;
  localparam logic [5:0]  AP    = 6'h2B;
  localparam logic [19:0] RPNA  = 20'h12345;
  localparam logic [19:0] RPNB  = 20'h6789A;

  // kinds (4 bits per slot, slot 0 lowest): 0 invalid, 1 wrong hash flag,
  // 2 grant pp10 A, 3 pp00 A, 4 pp00 B, 5 pp10 B, 7 pp01 A, 8 wrong api, 9 pp11 A
  typedef struct packed {
    logic [31:0] kinds;
    logic        hsel;
    logic        store;
    logic        key;
    logic [1:0]  rc0;
    logic [1:0]  res;
    logic [2:0]  slot;
    logic [4:0]  reads;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{32'h00000002, 1'b0, 1'b0, 1'b1, 2'b00, 2'b00, 3'd0, 5'd2},
    '{32'h20810810, 1'b0, 1'b1, 1'b1, 2'b00, 2'b00, 3'd7, 5'd9},
    '{32'h00020030, 1'b0, 1'b0, 1'b1, 2'b00, 2'b00, 3'd4, 5'd7},
    '{32'h00020403, 1'b0, 1'b0, 1'b1, 2'b00, 2'b11, 3'd0, 5'd5},
    '{32'h00000000, 1'b0, 1'b0, 1'b1, 2'b00, 2'b10, 3'd0, 5'd8},
    '{32'h00003003, 1'b0, 1'b0, 1'b1, 2'b00, 2'b01, 3'd3, 5'd10},
    '{32'h00000300, 1'b0, 1'b0, 1'b1, 2'b10, 2'b01, 3'd2, 5'd9},
    '{32'h00000002, 1'b0, 1'b1, 1'b1, 2'b11, 2'b00, 3'd0, 5'd2},
    '{32'h00000002, 1'b0, 1'b0, 1'b1, 2'b01, 2'b00, 3'd0, 5'd2},
    '{32'h00000021, 1'b1, 1'b0, 1'b1, 2'b00, 2'b00, 3'd1, 5'd3},
    '{32'h00000007, 1'b0, 1'b1, 1'b1, 2'b00, 2'b01, 3'd0, 5'd9},
    '{32'h00000007, 1'b0, 1'b0, 1'b1, 2'b00, 2'b00, 3'd0, 5'd2},
    '{32'h00000009, 1'b0, 1'b1, 1'b0, 2'b00, 2'b01, 3'd0, 5'd9},
    '{32'h00000003, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 3'd0, 5'd2},
    '{32'h00000003, 1'b0, 1'b1, 1'b0, 2'b00, 2'b00, 3'd0, 5'd2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] tbl_base = TBASE, grp_off = '0;
  logic hsel = 1'b0, store = 1'b0, key = 1'b0;
  logic [23:0] vsid = VS;
  logic [5:0] api = AP;
  logic busy, done;
  logic [1:0] result;
  logic [2:0] slot;
  logic [19:0] rpn;
  logic rd_req_valid, rd_req_ready, rd_rsp_ready, wr_valid, wr_ready;
  logic [31:0] rd_addr, wr_addr, wr_data;
  logic rd_rsp_valid;
  logic [31:0] rd_rsp_data;

  always #5 clk = ~clk;

  hpt_group_search u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .tbl_base(tbl_base),
    .grp_off(grp_off), .hsel(hsel), .store(store), .key(key), .vsid(vsid),
    .api(api), .busy(busy), .done(done), .result(result), .slot(slot),
    .rpn(rpn), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_addr(rd_addr), .rd_rsp_valid(rd_rsp_valid),
    .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data)
  );

  // behavioural memory with varying back-pressure and latency
  logic [31:0] img [0:255];
  logic [31:0] rd_log [0:31];
  logic [7:0]  cyc;
  logic        pend, clr;
  logic [1:0]  lat;
  logic [31:0] paddr, w_addr, w_data;
  int          rd_cnt, rsp_cnt, wr_cnt;

  assign rd_req_ready = !pend && (cyc[0] | cyc[2]);
  assign wr_ready     = cyc[1];

  always @(posedge clk) begin
    cyc <= cyc + 8'd1;
    if (!rst_n || clr) begin
      pend <= 1'b0; rd_rsp_valid <= 1'b0; rd_cnt <= 0; rsp_cnt <= 0; wr_cnt <= 0;
      lat <= 2'd0;
    end else begin
      if (rd_req_valid && rd_req_ready) begin
        pend  <= 1'b1;
        lat   <= 2'(cyc % 3);
        paddr <= rd_addr;
        if (rd_cnt < 32) rd_log[rd_cnt] <= rd_addr;
        rd_cnt <= rd_cnt + 1;
      end
      if (pend && !rd_rsp_valid) begin
        if (lat == 2'd0) begin
          rd_rsp_valid <= 1'b1;
          rd_rsp_data  <= img[8'((paddr - TBASE) >> 2)];
        end else lat <= lat - 2'd1;
      end
      if (rd_rsp_valid && rd_rsp_ready) begin
        rd_rsp_valid <= 1'b0;
        pend <= 1'b0;
        rsp_cnt <= rsp_cnt + 1;
      end
      if (wr_valid && wr_ready) begin
        wr_cnt <= wr_cnt + 1; w_addr <= wr_addr; w_data <= wr_data;
      end
    end
  end

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_w0(input logic [3:0] k, input logic hs);
    case (k)
      4'd0: return 32'h0;
      4'd1: return {1'b1, VS, ~hs, AP};
      4'd8: return {1'b1, VS, hs, AP ^ 6'h1};
      default: return {1'b1, VS, hs, AP};
    endcase
  endfunction

  function automatic logic [31:0] mk_w1(input logic [3:0] k, input logic [1:0] rc);
    logic [19:0] r;
    logic [1:0] pp;
    r = (k == 4'd4 || k == 4'd5) ? RPNB : RPNA;
    case (k)
      4'd2, 4'd5: pp = 2'b10;
      4'd7:       pp = 2'b01;
      4'd9:       pp = 2'b11;
      default:    pp = 2'b00;
    endcase
    return {r, 3'b000, rc, 5'b00000, pp};
  endfunction

  task automatic load_group(input int g, input logic [31:0] kinds,
                            input logic hs, input logic [1:0] rc);
    for (int s = 0; s < 8; s++) begin
      img[g*16 + 2*s]     = mk_w0(kinds[s*4 +: 4], hs);
      img[g*16 + 2*s + 1] = mk_w1(kinds[s*4 +: 4], rc);
    end
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
  endtask

  task automatic launch(input int g, input logic hs, input logic st, input logic ky);
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    grp_off = 32'(g * 64); hsel = hs; store = st; key = ky; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic addr_order(input int g, input string tag);
    bit ok = 1'b1;
    int n = (rd_cnt < 32) ? rd_cnt : 32;
    for (int i = 0; i < n; i++) begin
      if (rd_log[i] < TBASE + 32'(g*64) || rd_log[i] >= TBASE + 32'(g*64 + 64)) ok = 1'b0;
      if (i > 0 && rd_log[i] <= rd_log[i-1]) ok = 1'b0;
    end
    chk(ok, tag, "read address order/range", rd_log[0], TBASE + 32'(g*64));
  endtask

  initial begin : wd
    #1500000;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
    $finish;
  end

  initial begin
    bit ok;
    clr = 1'b0;
    cyc = 8'd0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!busy && !done && !rd_req_valid && !wr_valid, "R11", "idle after reset",
        {28'h0, busy, done, rd_req_valid, wr_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [3:0] kc;
      logic [31:0] w1o, w1n;
      logic [19:0] erpn;
      bit ewr;
      string rtag;
      load_group(i, VEC[i].kinds, VEC[i].hsel, VEC[i].rc0);
      launch(i, VEC[i].hsel, VEC[i].store, VEC[i].key);
      wait_done(ok);
      chk(ok, "R10", "done seen", 32'(ok), 32'h1);
      case (VEC[i].res)
        2'b00: rtag = "R4";
        2'b01: rtag = "R5";
        2'b11: rtag = "R6";
        default: rtag = "R7";
      endcase
      if (i >= 10) rtag = "R3";
      kc   = VEC[i].kinds[VEC[i].slot*4 +: 4];
      erpn = (VEC[i].res[1] == 1'b0) ? mk_w1(kc, 2'b00) >> 12 : 20'h0;
      chk(result == VEC[i].res, rtag, "result", 32'(result), 32'(VEC[i].res));
      chk(slot == VEC[i].slot, rtag, "slot", 32'(slot), 32'(VEC[i].slot));
      chk(rpn == erpn, rtag, "rpn", 32'(rpn), 32'(erpn));
      // R2: second word read only for matching slots
      chk(rd_cnt == int'(VEC[i].reads), "R2", "read count", 32'(rd_cnt), 32'(VEC[i].reads));
      chk(rsp_cnt == rd_cnt, "R9", "responses per request", 32'(rsp_cnt), 32'(rd_cnt));
      addr_order(i, "R1");
      // R8 write-back expectation
      w1o = mk_w1(kc, VEC[i].rc0);
      w1n = w1o | 32'h100 | ((VEC[i].res == 2'b00 && VEC[i].store) ? 32'h80 : 32'h0);
      ewr = (VEC[i].res[1] == 1'b0) && (w1n != w1o);
      chk(wr_cnt == int'(ewr), "R8", "write count", 32'(wr_cnt), 32'(ewr));
      if (ewr) begin
        chk(w_addr == TBASE + 32'(i*64) + 32'(VEC[i].slot)*8 + 4, "R8", "write addr",
            w_addr, TBASE + 32'(i*64) + 32'(VEC[i].slot)*8 + 4);
        chk(w_data == w1n, "R8", "write data", w_data, w1n);
      end
      @(negedge clk);
      chk(!done && !busy, "R10", "done single pulse", {30'h0, done, busy}, 32'h0);
    end

    // R1 explicit addresses for the full-scan hit in slot 7 (vector 1)
    load_group(1, VEC[1].kinds, 1'b0, 2'b00);
    launch(1, 1'b0, 1'b1, 1'b1);
    wait_done(ok);
    chk(rd_log[0] == TBASE + 32'd64, "R1", "slot0 word0 addr", rd_log[0], TBASE + 32'd64);
    chk(rd_log[7] == TBASE + 32'd64 + 32'd56, "R1", "slot7 word0 addr", rd_log[7], TBASE + 32'd120);
    chk(rd_log[8] == TBASE + 32'd64 + 32'd60, "R1", "slot7 word1 addr", rd_log[8], TBASE + 32'd124);
    @(negedge clk);

    // R10: start while busy is ignored
    load_group(15, 32'h20000000, 1'b0, 2'b00);
    load_group(0, 32'h00000002, 1'b1, 2'b00);
    launch(15, 1'b0, 1'b0, 1'b1);
    repeat (4) @(negedge clk);
    grp_off = 32'h0; hsel = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(ok);
    chk(result == 2'b00 && slot == 3'd7, "R10", "restart ignored result",
        {27'h0, result, slot}, {27'h0, 2'b00, 3'd7});
    chk(rd_cnt == 9, "R10", "restart ignored reads", 32'(rd_cnt), 32'd9);
    addr_order(15, "R10");
    @(negedge clk);
    chk(!busy, "R10", "idle after restart test", 32'(busy), 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule